// File: doc/BRIEF.md
# Single-Line MESI Snooping Coherence Controller

This block tracks the coherence state of one cache line in a bus-based snooping system that uses the four stable MESI states. Since winning the shared bus takes time after a processor access misses or needs ownership, the controller uses three extra waiting states. While in them it holds a bus request, keeps answering snoops from other caches, and completes the processor access only when its own bus transaction goes out. No line data or tags are stored here. The block only decides state moves, bus commands, shared-line responses and data-supply (flush) pulses.

A processor issues a read or write request level on `cpu_rd`/`cpu_wr` and holds it until `cpu_done` pulses. The bus side presents a grant on `bus_gnt` and the wired-OR shared result on `bus_shared_in` in the same cycle. In any cycle it may instead present a snooped command from another cache on `snp_valid`/`snp_cmd`. All outputs are registered, so every response appears in the cycle after the inputs that caused it.

Top module: `mesi_line_ctl`

## Requirements
- R1: After synchronous reset, `line_state` is 0 (Invalid) and `bus_req`, `bus_cmd_valid`, `bus_cmd`, `flush_out`, `shared_out` and `cpu_done` are all 0. State codes: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified, 4 Invalid-waiting-for-read, 5 Invalid-waiting-for-ownership, 6 Shared-waiting-for-upgrade. Bus command codes: 0 none, 1 read, 2 read-for-ownership, 3 upgrade.
- R2: A read request in state 0 moves the line to state 4 with `bus_req` high. On a grant, the next cycle shows `bus_cmd_valid`=1 with command 1, `cpu_done`=1 and `bus_req`=0. The line goes to state 1 if `bus_shared_in` was high in the grant cycle, otherwise to state 2.
- R3: A write request in state 0 moves the line to state 5. On a grant it issues command 2, goes to state 3 and pulses `cpu_done`.
- R4: A write request in state 1 moves the line to state 6. On a grant it issues command 3, goes to state 3 and pulses `cpu_done`.
- R5: With no bus activity, `cpu_done` pulses the next cycle for a read in states 1, 2 or 3 and for a write in state 3. A write in state 2 moves silently to state 3. A request is not taken in a cycle where `cpu_done` is already high.
- R6: In state 3, a snooped read gives `flush_out`=1, `shared_out`=1 and state 1. A snooped read-for-ownership gives `flush_out`=1 and state 0.
- R7: In states 1 or 2, a snooped read leaves or moves the line to state 1 with `shared_out`=1. A snooped read-for-ownership or upgrade moves the line to 0. `flush_out` is raised on a snooped read or read-for-ownership only when parameter SUPPLY_CLEAN is 1.
- R8: In state 6, a snooped read-for-ownership or upgrade moves the line to state 5, and the later grant issues command 2. A snooped read keeps state 6 and raises `shared_out`.
- R9: In states 4, 5 and 6, `cpu_done` stays 0 and `bus_req` stays 1 until a grant completes the transaction.
- R10: A snoop occupies its cycle. A grant or a processor request in the same cycle is not acted upon, and `bus_cmd_valid` and `flush_out` are never high together.
- R11: When read and write are requested together, the write is served.
- R12: Snoops in states 0, 4 and 5 raise neither `flush_out` nor `shared_out` and leave the state unchanged. A grant is ignored when the controller is not waiting for the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Processor read request, held until done |
| cpu_wr | input | 1 | Processor write request, held until done |
| cpu_done | output | 1 | One-cycle completion of the processor access |
| bus_req | output | 1 | Request for the bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_shared_in | input | 1 | Wired-OR shared result, valid with the grant |
| bus_cmd_valid | output | 1 | Own bus command issued this cycle |
| bus_cmd | output | 2 | Own bus command code |
| snp_valid | input | 1 | Snooped command from another cache present |
| snp_cmd | input | 2 | Snooped command code |
| shared_out | output | 1 | Shared-line assertion in answer to a snooped read |
| flush_out | output | 1 | Line data supply pulse |
| line_state | output | 3 | Current coherence state code |

## Verification
The bench aims at the races of the waiting states. The first is a snooped read-for-ownership hitting a pending upgrade. A design that missed it would issue an upgrade on a stale copy and end in Modified with wrong data. It also drives a grant in the same cycle as a snoop. A design that let the grant through would put two transactions on the bus in one cycle and lose the snoop. Other directed cases cover a processor request arriving with a snoop, simultaneous read and write, shared versus private read fills, and the silent Exclusive-to-Modified upgrade. Any slip there shows up as a wrong state code, a missing or extra flush, or a completion pulse in the wrong cycle.

// File: rtl/mesi_line_pkg.sv
`timescale 1ns/1ps
package mesi_line_pkg;
  localparam int ST_W  = 3;
  localparam int CMD_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_I  = 3'd0,
    ST_S  = 3'd1,
    ST_E  = 3'd2,
    ST_M  = 3'd3,
    ST_IS = 3'd4,
    ST_IM = 3'd5,
    ST_SM = 3'd6
  } line_st_e;

  typedef enum logic [CMD_W-1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_UPG  = 2'd3
  } bus_cmd_e;

  function automatic logic waiting(input line_st_e s);
    return (s == ST_IS) || (s == ST_IM) || (s == ST_SM);
  endfunction
endpackage

// File: rtl/mesi_snoop_eval.sv
`timescale 1ns/1ps
module mesi_snoop_eval
  import mesi_line_pkg::*;
#(
  parameter int SUPPLY_CLEAN = 1
) (
  input  line_st_e         st,
  input  logic             snp_valid,
  input  logic [CMD_W-1:0] snp_cmd,
  output logic             active,
  output line_st_e         nxt,
  output logic             flush,
  output logic             shared
);
  bus_cmd_e c;
  logic     clean_fl;

  assign c = bus_cmd_e'(snp_cmd);

  generate
    if (SUPPLY_CLEAN != 0) begin : g_supply
      assign clean_fl = 1'b1;
    end else begin : g_nosupply
      assign clean_fl = 1'b0;
    end
  endgenerate

  always_comb begin
    active = snp_valid && (c != BC_NONE);
    nxt    = st;
    flush  = 1'b0;
    shared = 1'b0;
    if (active) begin
      unique case (st)
        ST_M: begin
          if (c == BC_RD) begin
            nxt    = ST_S;
            flush  = 1'b1;
            shared = 1'b1;
          end else begin
            nxt   = ST_I;
            flush = (c == BC_RDX);
          end
        end
        ST_E, ST_S: begin
          if (c == BC_RD) begin
            nxt    = ST_S;
            shared = 1'b1;
            flush  = clean_fl;
          end else begin
            nxt   = ST_I;
            flush = (c == BC_RDX) && clean_fl;
          end
        end
        ST_SM: begin
          if (c == BC_RD) begin
            shared = 1'b1;
            flush  = clean_fl;
          end else begin
            nxt   = ST_IM;
            flush = (c == BC_RDX) && clean_fl;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_proc_eval.sv
`timescale 1ns/1ps
module mesi_proc_eval
  import mesi_line_pkg::*;
(
  input  line_st_e st,
  input  logic     cpu_rd,
  input  logic     cpu_wr,
  input  logic     done_q,
  output logic     accept,
  output line_st_e nxt,
  output logic     done
);
  always_comb begin
    accept = !done_q && !waiting(st) && (cpu_rd || cpu_wr);
    nxt    = st;
    done   = 1'b0;
    if (accept) begin
      if (cpu_wr) begin
        unique case (st)
          ST_I:    nxt = ST_IM;
          ST_S:    nxt = ST_SM;
          ST_E: begin
            nxt  = ST_M;
            done = 1'b1;
          end
          default: done = 1'b1;
        endcase
      end else begin
        if (st == ST_I) nxt = ST_IS;
        else            done = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesi_grant_eval.sv
`timescale 1ns/1ps
module mesi_grant_eval
  import mesi_line_pkg::*;
(
  input  line_st_e st,
  input  logic     bus_gnt,
  input  logic     bus_shared_in,
  output logic     fire,
  output line_st_e nxt,
  output bus_cmd_e cmd
);
  always_comb begin
    fire = bus_gnt && waiting(st);
    nxt  = st;
    cmd  = BC_NONE;
    if (fire) begin
      unique case (st)
        ST_IS: begin
          cmd = BC_RD;
          nxt = bus_shared_in ? ST_S : ST_E;
        end
        ST_IM: begin
          cmd = BC_RDX;
          nxt = ST_M;
        end
        default: begin
          cmd = BC_UPG;
          nxt = ST_M;
        end
      endcase
    end
  end
endmodule

// File: rtl/mesi_line_ctl.sv
`timescale 1ns/1ps
module mesi_line_ctl
  import mesi_line_pkg::*;
#(
  parameter int SUPPLY_CLEAN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  output logic             cpu_done,
  output logic             bus_req,
  input  logic             bus_gnt,
  input  logic             bus_shared_in,
  output logic             bus_cmd_valid,
  output logic [CMD_W-1:0] bus_cmd,
  input  logic             snp_valid,
  input  logic [CMD_W-1:0] snp_cmd,
  output logic             shared_out,
  output logic             flush_out,
  output logic [ST_W-1:0]  line_state
);
  line_st_e state_q, state_d;
  bus_cmd_e cmd_d;
  logic     cv_d, done_d, fl_d, sh_d, req_d;

  logic     sn_active, sn_flush, sn_shared;
  line_st_e sn_nxt;
  logic     gr_fire;
  line_st_e gr_nxt;
  bus_cmd_e gr_cmd;
  logic     pr_accept, pr_done;
  line_st_e pr_nxt;

  mesi_snoop_eval #(.SUPPLY_CLEAN(SUPPLY_CLEAN)) u_snoop (
    .st(state_q), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .active(sn_active), .nxt(sn_nxt), .flush(sn_flush), .shared(sn_shared)
  );

  mesi_grant_eval u_grant (
    .st(state_q), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .fire(gr_fire), .nxt(gr_nxt), .cmd(gr_cmd)
  );

  mesi_proc_eval u_proc (
    .st(state_q), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .done_q(cpu_done),
    .accept(pr_accept), .nxt(pr_nxt), .done(pr_done)
  );

  // Snoop owns the cycle; then own grant; then processor access.
  always_comb begin
    state_d = state_q;
    cmd_d   = BC_NONE;
    cv_d    = 1'b0;
    done_d  = 1'b0;
    fl_d    = 1'b0;
    sh_d    = 1'b0;
    if (sn_active) begin
      state_d = sn_nxt;
      fl_d    = sn_flush;
      sh_d    = sn_shared;
    end else if (gr_fire) begin
      state_d = gr_nxt;
      cmd_d   = gr_cmd;
      cv_d    = 1'b1;
      done_d  = 1'b1;
    end else if (pr_accept) begin
      state_d = pr_nxt;
      done_d  = pr_done;
    end
    req_d = waiting(state_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_I;
      bus_req       <= 1'b0;
      bus_cmd_valid <= 1'b0;
      bus_cmd       <= BC_NONE;
      cpu_done      <= 1'b0;
      flush_out     <= 1'b0;
      shared_out    <= 1'b0;
    end else begin
      state_q       <= state_d;
      bus_req       <= req_d;
      bus_cmd_valid <= cv_d;
      bus_cmd       <= cmd_d;
      cpu_done      <= done_d;
      flush_out     <= fl_d;
      shared_out    <= sh_d;
    end
  end

  assign line_state = state_q;
endmodule

// File: rtl/mesi_line_ctl_chk.sv
`timescale 1ns/1ps
module mesi_line_ctl_chk
  import mesi_line_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cpu_rd,
  input logic             cpu_wr,
  input logic             cpu_done,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             bus_shared_in,
  input logic             bus_cmd_valid,
  input logic [CMD_W-1:0] bus_cmd,
  input logic             snp_valid,
  input logic [CMD_W-1:0] snp_cmd,
  input logic             shared_out,
  input logic             flush_out,
  input logic [ST_W-1:0]  line_state
);
  logic snp_on;
  assign snp_on = snp_valid && (snp_cmd != 2'd0);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> bus_req);

  // R2
  issue_done_chk: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_valid |-> (cpu_done && !bus_req));

  // R5
  done_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> (line_state < 3'd4));

  // R6
  m_snoop_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd3 && snp_valid && snp_cmd == 2'd1) |=> (flush_out && shared_out && line_state == 3'd1));

  // R3
  im_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd5 && bus_gnt && !snp_on) |=> (bus_cmd_valid && bus_cmd == 2'd2 && line_state == 3'd3));

  // R8
  sm_demote_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd6 && snp_valid && snp_cmd >= 2'd2) |=> (line_state == 3'd5));

  // R12
  inv_snoop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (line_state == 3'd0 && snp_valid) |=> (!flush_out && !shared_out));

  // R10
  one_bus_act_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_cmd_valid, flush_out}));
endmodule

bind mesi_line_ctl mesi_line_ctl_chk u_chk (.*);

// File: tb/mesi_line_ctl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctl_tb;
  localparam int SUPPLY_CLEAN = 1;

  logic       clk = 1'b0;
  logic       rst;
  logic       cpu_rd, cpu_wr, bus_gnt, bus_shared_in, snp_valid;
  logic [1:0] snp_cmd;
  logic       cpu_done, bus_req, bus_cmd_valid, shared_out, flush_out;
  logic [1:0] bus_cmd;
  logic [2:0] line_state;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mesi_line_ctl #(.SUPPLY_CLEAN(SUPPLY_CLEAN)) u_dut (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .shared_out(shared_out), .flush_out(flush_out),
    .line_state(line_state)
  );

  // reference model state
  logic [2:0] m_st;
  logic       m_done;
  logic [2:0] e_st;
  logic       e_req, e_cv, e_fl, e_sh, e_done;
  logic [1:0] e_cmd;
  string      e_tag;

  function automatic logic is_wait(input logic [2:0] s);
    return (s >= 3'd4) && (s <= 3'd6);
  endfunction

  task automatic model(input logic rd, wr, gnt, sv, input logic [1:0] sc, input logic sh);
    logic sn;
    logic wt;
    logic cln;
    cln = (SUPPLY_CLEAN != 0);
    sn = sv && (sc != 2'd0);
    wt = is_wait(m_st);
    e_st = m_st; e_cv = 0; e_cmd = 0; e_fl = 0; e_sh = 0; e_done = 0;
    e_tag = "R5";
    if (sn) begin
      case (m_st)
        3'd3: begin
          e_tag = "R6";
          if (sc == 2'd1) begin e_st = 3'd1; e_fl = 1; e_sh = 1; end
          else begin e_st = 3'd0; e_fl = (sc == 2'd2); end
        end
        3'd1, 3'd2: begin
          e_tag = "R7";
          if (sc == 2'd1) begin e_st = 3'd1; e_sh = 1; e_fl = cln; end
          else begin e_st = 3'd0; e_fl = (sc == 2'd2) && cln; end
        end
        3'd6: begin
          e_tag = "R8";
          if (sc == 2'd1) begin e_sh = 1; e_fl = cln; end
          else begin e_st = 3'd5; e_fl = (sc == 2'd2) && cln; end
        end
        default: e_tag = "R12";
      endcase
      if ((wt && gnt) || (!wt && !m_done && (rd || wr))) e_tag = "R10";
    end else if (wt && gnt) begin
      e_cv = 1; e_done = 1;
      case (m_st)
        3'd4: begin e_tag = "R2"; e_cmd = 2'd1; e_st = sh ? 3'd1 : 3'd2; end
        3'd5: begin e_tag = "R3"; e_cmd = 2'd2; e_st = 3'd3; end
        default: begin e_tag = "R4"; e_cmd = 2'd3; e_st = 3'd3; end
      endcase
    end else if (wt) begin
      e_tag = "R9";
    end else if (!m_done && (rd || wr)) begin
      if (wr) begin
        e_tag = rd ? "R11" : "R5";
        case (m_st)
          3'd0: begin e_st = 3'd5; if (!rd) e_tag = "R3"; end
          3'd1: begin e_st = 3'd6; if (!rd) e_tag = "R4"; end
          3'd2: begin e_st = 3'd3; e_done = 1; end
          default: e_done = 1;
        endcase
      end else begin
        if (m_st == 3'd0) begin e_st = 3'd4; e_tag = "R2"; end
        else e_done = 1;
      end
    end else if (gnt) begin
      e_tag = "R12";
    end
    e_req = is_wait(e_st);
  endtask

  task automatic compare(input string tag);
    checks++;
    if ({line_state, bus_req, bus_cmd_valid, bus_cmd, flush_out, shared_out, cpu_done} !==
        {e_st, e_req, e_cv, e_cmd, e_fl, e_sh, e_done}) begin
      fails++;
      $display("FAIL %s: st=%0d req=%0b cv=%0b cmd=%0d fl=%0b sh=%0b done=%0b expected st=%0d req=%0b cv=%0b cmd=%0d fl=%0b sh=%0b done=%0b",
               tag, line_state, bus_req, bus_cmd_valid, bus_cmd, flush_out, shared_out, cpu_done,
               e_st, e_req, e_cv, e_cmd, e_fl, e_sh, e_done);
    end
  endtask

  // Called at a negative edge: drive, let one rising edge pass, check at the next negative edge.
  task automatic cyc(input logic rd, wr, gnt, sv, input logic [1:0] sc, input logic sh);
    cpu_rd = rd; cpu_wr = wr; bus_gnt = gnt; snp_valid = sv; snp_cmd = sc; bus_shared_in = sh;
    model(rd, wr, gnt, sv, sc, sh);
    @(posedge clk);
    @(negedge clk);
    compare(e_tag);
    m_st = e_st;
    m_done = e_done;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    rst = 1; cpu_rd = 0; cpu_wr = 0; bus_gnt = 0; bus_shared_in = 0; snp_valid = 0; snp_cmd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    m_st = 0; m_done = 0;
    e_st = 0; e_req = 0; e_cv = 0; e_cmd = 0; e_fl = 0; e_sh = 0; e_done = 0;
    compare("R1");

    // R2: private read fill with a stall
    cyc(1,0,0,0,0,0);
    cyc(1,0,0,0,0,0);
    cyc(1,0,1,0,0,0);
    cyc(0,0,0,0,0,0);
    // R5: silent E->M
    cyc(0,1,0,0,0,0);
    cyc(0,0,0,0,0,0);
    // R6: snooped read in M
    cyc(0,0,0,1,2'd1,0);
    // R4 / R8: upgrade pending, demoted by RdX, grant issues RdX
    cyc(0,1,0,0,0,0);
    cyc(0,1,0,1,2'd2,0);
    cyc(0,1,1,0,0,0);
    cyc(0,0,0,0,0,0);
    // R10: snoop together with processor write in M
    cyc(0,1,0,1,2'd2,0);
    cyc(0,1,0,0,0,0);
    // R10: grant together with snoop
    cyc(0,1,1,1,2'd1,0);
    cyc(0,1,1,0,0,0);
    cyc(0,0,0,1,2'd2,0);
    // R11: read and write together
    cyc(1,1,0,0,0,0);
    cyc(1,1,1,0,0,0);
    cyc(0,0,0,0,0,0);
    // R2: shared read fill
    cyc(0,0,0,1,2'd2,0);
    cyc(1,0,0,0,0,0);
    cyc(1,0,1,0,0,1);
    cyc(0,0,0,0,0,0);
    // R8: snooped read while upgrade pending, then R4 upgrade
    cyc(0,1,0,0,0,0);
    cyc(0,1,0,1,2'd1,0);
    cyc(0,1,1,0,0,0);
    cyc(0,0,0,0,0,0);
    // R12: grant with no request; snoop upgrade in M
    cyc(0,0,1,0,0,0);
    cyc(0,0,0,1,2'd3,0);
    cyc(0,0,0,1,2'd1,0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic rd, wr, gnt, sv, sh;
      logic [1:0] sc;
      rd  = ($urandom % 3) == 0;
      wr  = ($urandom % 4) == 0;
      gnt = ($urandom % 3) == 0;
      sv  = ($urandom % 5) == 0;
      sc  = 2'($urandom % 4);
      sh  = 1'($urandom % 2);
      cyc(rd, wr, gnt, sv, sc, sh);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule